// File: doc/BRIEF.md
# Radix-Weighted Pipeline Code Reconstructor

This block turns the raw per-stage decisions of a multistage pipelined or cyclic converter into one corrected output word. A real stage does not amplify its residue by exactly two: capacitor mismatch and finite amplifier gain move its equivalent radix away from the ideal value. Instead of the usual shift-and-add with fixed weights of two, the block folds in a separate, programmable radix for every inter-stage gain. An external estimator loop keeps those radices up to date while conversions continue.

A conversion starts when `in_valid` is high while the block is idle. The digits are then combined with one multiply-accumulate per clock, in Horner form from the first (most significant) stage towards the last: `acc = acc * radix[k-1] + digit[k]`. This gives each digit the product of the radices of every gain stage between it and the back end. The digits are either three-level (1.5 bits per stage) or two-level (1 bit per stage), chosen by a mode input. The accumulated value is truncated to the output fraction, saturated to the signed output width, and presented with a one-cycle valid pulse.

The radix bank holds one unsigned fixed-point value per gain stage (all stages except the last) and resets to exactly 2.0. Each conversion works on a private copy of the bank taken when it is accepted, so a write that arrives mid-conversion only affects the next conversion.

Top module: `radix_code_rebuilder`

## Requirements
- R1: After reset, `busy` and `out_valid` are low and every radix register holds 2.0, so a conversion with no prior writes yields the ideal binary-weighted result.
- R2: With `in_one_bit` low, stage k's digit is the field `in_digits[2k+1:2k]` (stage 0 is the first, most significant stage): 2'b01 means +1, 2'b11 means -1, and 2'b00 and 2'b10 both mean 0.
- R3: With `in_one_bit` high, stage k's digit is -1 when bit 2k+1 is 1 and +1 when it is 0. Bit 2k is ignored, so no digit is ever 0 in this mode.
- R4: The accumulator (24 fractional bits) starts at d0·2^24. For k = 1..N-1 it becomes floor(acc·r[k-1] / 2^24) + dk·2^24, where r[k-1] is radix register k-1. The last stage has no radix register.
- R5: `out_code` = floor(acc / 2^(24-OUT_FRAC)), saturated to the signed range of OUT_W bits (default: 4 fractional bits, 16 bits wide, limits 32767 and -32768).
- R6: A conversion is accepted on a rising edge where `in_valid` is high and `busy` is low. `busy` is high from the next cycle. `out_valid` pulses for one cycle, N_STAGES edges after the accepting edge, with `busy` already low in that cycle.
- R7: `in_valid` while `busy` is high is ignored: it neither restarts the conversion nor produces an extra result.
- R8: A cycle with `cfg_we` high and `cfg_addr` < N_STAGES-1 loads `cfg_wdata` into that radix register. A write to an address at or above N_STAGES-1 changes nothing.
- R9: A radix write made while a conversion is running does not change that conversion's result and takes effect from the next conversion.
- R10: Radix registers are unsigned with 2 integer and 24 fractional bits (26 bits), so values from 2.0 up to just under 4.0 set the top bit and are still positive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Start a conversion with the digits present |
| in_digits | input | 2*N_STAGES | Per-stage digit codes, stage 0 in the lowest field |
| in_one_bit | input | 1 | 1: two-level digit mode, 0: three-level digit mode |
| cfg_we | input | 1 | Radix register write enable |
| cfg_addr | input | clog2(N_STAGES) | Radix register index |
| cfg_wdata | input | RAD_W | Radix value, unsigned 2.24 |
| busy | output | 1 | A conversion is in progress |
| out_valid | output | 1 | One-cycle strobe for `out_code` |
| out_code | output | OUT_W | Corrected signed code with OUT_FRAC fractional bits |

## Verification
The assertions assume that the digit word, the mode and `in_valid` are settled before each rising edge, and that the producer keeps its radix values in the unsigned range, so the accumulator width chosen for radices below 4.0 cannot overflow. The stimulus draws digits, modes and radices from a seeded generator: radices within a quarter of 2.0 for the random part, plus directed 1.75 and 3.9 settings for the non-ideal and saturation cases. Every input changes on the falling edge. Mid-conversion strobes and radix writes are driven on purpose to exercise the ignore and deferral rules.

// File: rtl/rwr_pkg.sv
package rwr_pkg;

  localparam int RAD_INT_BITS  = 2;
  localparam int RAD_FRAC_BITS = 24;

  typedef logic signed [1:0] digit_t;

  // Map a two-bit stage field to a signed digit.
  function automatic digit_t decode_digit(input logic [1:0] code, input logic one_bit);
    digit_t d;
    if (one_bit) begin
      d = code[1] ? -2'sd1 : 2'sd1;
    end else begin
      case (code)
        2'b01:   d = 2'sd1;
        2'b11:   d = -2'sd1;
        default: d = 2'sd0;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/rwr_rst_sync.sv
module rwr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/rwr_digit_decode.sv
module rwr_digit_decode #(
  parameter int N_STAGES = 8
) (
  input  logic [2*N_STAGES-1:0]              codes,
  input  logic                               one_bit,
  output rwr_pkg::digit_t [N_STAGES-1:0]     digs
);

  for (genvar g = 0; g < N_STAGES; g++) begin : g_dec
    assign digs[g] = rwr_pkg::decode_digit(codes[2*g +: 2], one_bit);
  end

endmodule

// File: rtl/rwr_radix_bank.sv
module rwr_radix_bank #(
  parameter int N_RAD    = 7,
  parameter int RAD_W    = 26,
  parameter int RAD_FRAC = 24,
  parameter int ADDR_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [RAD_W-1:0]            cfg_wdata,
  input  logic                        snap,
  output logic [N_RAD-1:0][RAD_W-1:0] work
);

  localparam logic [RAD_W-1:0] RADIX_TWO = RAD_W'(1) << (RAD_FRAC + 1);

  logic [N_RAD-1:0][RAD_W-1:0] live_q, live_d;
  logic [N_RAD-1:0][RAD_W-1:0] work_q, work_d;
  logic                        live_en;

  // Next-state: programmable bank and per-conversion copy.
  always_comb begin
    live_d  = live_q;
    live_en = 1'b0;
    for (int i = 0; i < N_RAD; i++) begin
      if (cfg_we && (cfg_addr == ADDR_W'(i))) begin
        live_d[i] = cfg_wdata;
        live_en   = 1'b1;
      end
    end
    work_d = live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_RAD; i++) live_q[i] <= RADIX_TWO;
    end else if (live_en) begin
      live_q <= live_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_RAD; i++) work_q[i] <= RADIX_TWO;
    end else if (snap) begin
      work_q <= work_d;
    end
  end

  assign work = work_q;

  // R8: an in-range write lands in the addressed register
  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (int'(cfg_addr) < N_RAD)) |=> (live_q[$past(cfg_addr)] == $past(cfg_wdata)));

  // R8: an out-of-range write leaves the bank untouched
  p_bad_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (int'(cfg_addr) >= N_RAD)) |=> $stable(live_q));

  // R9: the working copy is the bank as it stood at acceptance
  p_snap_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (work_q == $past(live_q)));

endmodule

// File: rtl/rwr_mac_engine.sv
module rwr_mac_engine #(
  parameter int N_STAGES = 8,
  parameter int RAD_W    = 26,
  parameter int RAD_FRAC = 24,
  parameter int ACC_W    = 41
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  rwr_pkg::digit_t [N_STAGES-1:0]    digs_in,
  input  logic [N_STAGES-2:0][RAD_W-1:0]    radix,
  output logic                              busy,
  output logic                              snap,
  output logic                              done,
  output logic signed [ACC_W-1:0]           acc
);

  localparam int STEP_W = $clog2(N_STAGES + 1);
  localparam int PROD_W = ACC_W + RAD_W + 1;

  logic                               busy_q, busy_d;
  logic [STEP_W-1:0]                  step_q, step_d;
  logic signed [ACC_W-1:0]            acc_q, acc_d, acc_mac;
  rwr_pkg::digit_t [N_STAGES-1:1]     digs_q, digs_d;
  rwr_pkg::digit_t                    d_sel;
  logic [RAD_W-1:0]                   r_sel;
  logic signed [PROD_W-1:0]           prod;
  logic                               start, fin;
  logic                               acc_en, digs_en;

  always_comb begin
    start = in_valid && !busy_q;
    fin   = busy_q && (step_q == STEP_W'(N_STAGES));

    r_sel = '0;
    d_sel = '0;
    for (int i = 1; i < N_STAGES; i++) begin
      if (step_q == STEP_W'(i)) begin
        r_sel = radix[i-1];
        d_sel = digs_q[i];
      end
    end

    prod    = PROD_W'(acc_q) * PROD_W'($signed({1'b0, r_sel}));
    acc_mac = ACC_W'(prod >>> RAD_FRAC) + (ACC_W'(d_sel) <<< RAD_FRAC);

    busy_d  = busy_q;
    step_d  = step_q;
    acc_d   = acc_q;
    digs_d  = digs_q;
    acc_en  = 1'b0;
    digs_en = 1'b0;

    if (start) begin
      busy_d  = 1'b1;
      step_d  = STEP_W'(1);
      acc_d   = ACC_W'(digs_in[0]) <<< RAD_FRAC;
      digs_d  = digs_in[N_STAGES-1:1];
      acc_en  = 1'b1;
      digs_en = 1'b1;
    end else if (fin) begin
      busy_d = 1'b0;
      step_d = '0;
    end else if (busy_q) begin
      acc_d  = acc_mac;
      step_d = step_q + STEP_W'(1);
      acc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       digs_q <= '0;
    else if (digs_en) digs_q <= digs_d;
  end

  assign busy = busy_q;
  assign snap = start;
  assign done = fin;
  assign acc  = acc_q;

  // R6: an accepted request starts the first accumulation step
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy_q) |=> (busy_q && (step_q == STEP_W'(1))));

  // R6: the step index stays inside the conversion window
  p_step_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((step_q >= STEP_W'(1)) && (step_q <= STEP_W'(N_STAGES))));

  // R7: a strobe during a conversion does not restart it
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && in_valid && !fin) |=> (step_q == $past(step_q) + STEP_W'(1)));

endmodule

// File: rtl/rwr_out_stage.sv
module rwr_out_stage #(
  parameter int ACC_W    = 41,
  parameter int RAD_FRAC = 24,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] acc,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_code
);

  localparam int SHIFT = RAD_FRAC - OUT_FRAC;
  localparam logic signed [ACC_W-1:0] SAT_HI =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] scaled;
  logic signed [OUT_W-1:0] code_d, code_q;
  logic                    valid_q;

  always_comb begin
    scaled = acc >>> SHIFT;
    if (scaled > SAT_HI)      code_d = SAT_HI[OUT_W-1:0];
    else if (scaled < SAT_LO) code_d = SAT_LO[OUT_W-1:0];
    else                      code_d = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (load) code_q <= code_d;
  end

  assign out_valid = valid_q;
  assign out_code  = code_q;

  // R6: the result strobe lasts a single cycle
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5: the presented code holds between results
  p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(out_code));

endmodule

// File: rtl/radix_code_rebuilder.sv
module radix_code_rebuilder #(
  parameter int N_STAGES = 8,
  parameter int RAD_W    = rwr_pkg::RAD_INT_BITS + rwr_pkg::RAD_FRAC_BITS,
  parameter int RAD_FRAC = rwr_pkg::RAD_FRAC_BITS,
  parameter int OUT_W    = 16,
  parameter int OUT_FRAC = 4,
  parameter int ADDR_W   = $clog2(N_STAGES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [2*N_STAGES-1:0]     in_digits,
  input  logic                      in_one_bit,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [RAD_W-1:0]          cfg_wdata,
  output logic                      busy,
  output logic                      out_valid,
  output logic signed [OUT_W-1:0]   out_code
);

  localparam int N_RAD = N_STAGES - 1;
  localparam int ACC_W = 2 * N_STAGES + 1 + RAD_FRAC;

  logic                           rst_n_sync;
  rwr_pkg::digit_t [N_STAGES-1:0] dec;
  logic [N_RAD-1:0][RAD_W-1:0]    work;
  logic                           snap, done;
  logic signed [ACC_W-1:0]        acc;

  rwr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  rwr_digit_decode #(.N_STAGES(N_STAGES)) u_decode (
    .codes   (in_digits),
    .one_bit (in_one_bit),
    .digs    (dec)
  );

  rwr_radix_bank #(
    .N_RAD(N_RAD), .RAD_W(RAD_W), .RAD_FRAC(RAD_FRAC), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .snap      (snap),
    .work      (work)
  );

  rwr_mac_engine #(
    .N_STAGES(N_STAGES), .RAD_W(RAD_W), .RAD_FRAC(RAD_FRAC), .ACC_W(ACC_W)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .in_valid (in_valid),
    .digs_in  (dec),
    .radix    (work),
    .busy     (busy),
    .snap     (snap),
    .done     (done),
    .acc      (acc)
  );

  rwr_out_stage #(
    .ACC_W(ACC_W), .RAD_FRAC(RAD_FRAC), .OUT_W(OUT_W), .OUT_FRAC(OUT_FRAC)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .load      (done),
    .acc       (acc),
    .out_valid (out_valid),
    .out_code  (out_code)
  );

  // R3: two-level mode never yields a zero digit
  for (genvar g = 0; g < N_STAGES; g++) begin : g_chk
    p_onebit_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
      (in_valid && in_one_bit) |-> (dec[g] != 2'sd0));
  end

  // R9: the conversion's radix copy does not move while busy
  p_work_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    busy |=> $stable(work));

  // R6: a result appears only once the engine has gone idle
  p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    out_valid |-> !busy);

endmodule

// File: tb/radix_code_rebuilder_tb.sv
module radix_code_rebuilder_tb;

  localparam int N     = 8;
  localparam int RW    = 26;
  localparam int FR    = 24;
  localparam int OW    = 16;
  localparam int OF    = 4;
  localparam int NR    = N - 1;
  localparam logic [RW-1:0] R_TWO = 26'h2000000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [2*N-1:0]    in_digits;
  logic              in_one_bit;
  logic              cfg_we;
  logic [2:0]        cfg_addr;
  logic [RW-1:0]     cfg_wdata;
  logic              busy;
  logic              out_valid;
  logic signed [OW-1:0] out_code;

  int checks = 0;
  int errors = 0;

  logic [NR-1:0][RW-1:0] rmodel;

  always #10 clk = ~clk;

  radix_code_rebuilder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_digits(in_digits),
    .in_one_bit(in_one_bit), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .out_valid(out_valid), .out_code(out_code)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected code from the requirement formulas (R2, R3, R4, R5)
  function automatic longint model(input logic [2*N-1:0] dig, input logic mode);
    logic signed [127:0] acc;
    logic signed [127:0] d;
    logic signed [127:0] q;
    acc = '0;
    for (int k = 0; k < N; k++) begin
      logic [1:0] c;
      c = dig[2*k +: 2];
      if (mode) d = c[1] ? -128'sd1 : 128'sd1;
      else if (c == 2'b01) d = 128'sd1;
      else if (c == 2'b11) d = -128'sd1;
      else d = 128'sd0;
      if (k == 0) acc = d <<< FR;
      else acc = ((acc * $signed({1'b0, rmodel[k-1]})) >>> FR) + (d <<< FR);
    end
    q = acc >>> (FR - OF);
    if (q > 128'sd32767) q = 128'sd32767;
    if (q < -128'sd32768) q = -128'sd32768;
    return longint'(q);
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [RW-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < NR) rmodel[a] = v;
  endtask

  // kind 0: plain; 1: foreign strobe while busy; 2: radix write while busy
  task automatic run_conv(input logic [2*N-1:0] dig, input logic mode, input int kind,
                          input logic [2:0] wa, input logic [RW-1:0] wv,
                          output longint code, output int lat, output bit busy_ok);
    int cnt;
    @(negedge clk);
    in_valid = 1'b1; in_digits = dig; in_one_bit = mode;
    cnt = 0;
    busy_ok = 1'b1;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        in_valid = 1'b0;
        if (!busy) busy_ok = 1'b0;
      end
      if (kind == 1 && cnt == 2) begin
        in_valid = 1'b1; in_digits = ~dig; in_one_bit = ~mode;
      end
      if (kind == 1 && cnt == 3) in_valid = 1'b0;
      if (kind == 2 && cnt == 3) begin
        cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wv;
      end
      if (kind == 2 && cnt == 4) cfg_we = 1'b0;
    end while (!out_valid && cnt < 40);
    if (busy) busy_ok = 1'b0;
    code = longint'(out_code);
    lat = cnt - 1;
    if (kind == 2 && wa < NR) rmodel[wa] = wv;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint code, exp;
    int lat;
    bit bok;
    logic [2*N-1:0] dg;
    logic md;
    void'($urandom(32'd20240611));

    rst_n = 1'b0; in_valid = 1'b0; in_digits = '0; in_one_bit = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int i = 0; i < NR; i++) rmodel[i] = R_TWO;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R1 reset idle", {busy, out_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && out_valid == 1'b0, "R1 idle after release", {busy, out_valid}, 0);

    // R1/R2/R6: all +1 with reset radices gives 255 * 16
    run_conv({N{2'b01}}, 1'b0, 0, 3'd0, '0, code, lat, bok);
    chk(code == 4080, "R1 R2 all plus one", code, 4080);
    chk(lat == N, "R6 latency", lat, N);
    chk(bok, "R6 busy window", bok, 1);

    run_conv({N{2'b11}}, 1'b0, 0, 3'd0, '0, code, lat, bok);
    chk(code == -4080, "R2 all minus one", code, -4080);
    run_conv({N{2'b10}}, 1'b0, 0, 3'd0, '0, code, lat, bok);
    chk(code == 0, "R2 code 10 is zero", code, 0);
    run_conv(16'b01_11_00_01_10_11_01_01, 1'b0, 0, 3'd0, '0, code, lat, bok);
    exp = model(16'b01_11_00_01_10_11_01_01, 1'b0);
    chk(code == exp, "R2 mixed pattern", code, exp);

    // R3: two-level mode, low bit ignored
    run_conv({N{2'b01}}, 1'b1, 0, 3'd0, '0, code, lat, bok);
    chk(code == 4080, "R3 one-bit plus", code, 4080);
    run_conv({N{2'b10}}, 1'b1, 0, 3'd0, '0, code, lat, bok);
    chk(code == -4080, "R3 one-bit minus", code, -4080);
    run_conv({N{2'b00}}, 1'b1, 0, 3'd0, '0, code, lat, bok);
    chk(code == 4080, "R3 zero code reads as plus", code, 4080);

    // R4: non-ideal radix 1.75 everywhere
    for (int i = 0; i < NR; i++) cfg_write(3'(i), 26'h1C00000);
    run_conv({N{2'b01}}, 1'b0, 0, 3'd0, '0, code, lat, bok);
    exp = model({N{2'b01}}, 1'b0);
    chk(code == exp, "R4 radix 1.75", code, exp);

    // R8: out-of-range address ignored
    cfg_write(3'd7, 26'h0000001);
    run_conv({N{2'b01}}, 1'b0, 0, 3'd0, '0, code, lat, bok);
    chk(code == exp, "R8 bad address ignored", code, exp);

    // R5/R10: radix 3.9 with top bit set saturates
    for (int i = 0; i < NR; i++) cfg_write(3'(i), 26'd65431142);
    run_conv({N{2'b01}}, 1'b0, 0, 3'd0, '0, code, lat, bok);
    chk(code == 32767, "R5 R10 saturate high", code, 32767);
    run_conv({N{2'b11}}, 1'b0, 0, 3'd0, '0, code, lat, bok);
    chk(code == -32768, "R5 saturate low", code, -32768);

    // R9: write during conversion deferred
    for (int i = 0; i < NR; i++) cfg_write(3'(i), R_TWO);
    run_conv({N{2'b01}}, 1'b0, 2, 3'd0, 26'h1800000, code, lat, bok);
    chk(code == 4080, "R9 write deferred", code, 4080);
    run_conv({N{2'b01}}, 1'b0, 0, 3'd0, '0, code, lat, bok);
    exp = model({N{2'b01}}, 1'b0);
    chk(code == exp && exp != 4080, "R9 write applied next", code, exp);

    // R7: strobe while busy ignored
    exp = model(16'h5A3C, 1'b0);
    run_conv(16'h5A3C, 1'b0, 1, 3'd0, '0, code, lat, bok);
    chk(code == exp, "R7 result kept", code, exp);
    begin
      int extra;
      extra = 0;
      for (int i = 0; i < N + 4; i++) begin
        @(negedge clk);
        if (out_valid) extra++;
      end
      chk(extra == 0, "R7 no extra result", extra, 0);
    end

    // Random part: R4/R5/R6/R8
    for (int t = 0; t < 300; t++) begin
      if (t % 25 == 0) begin
        for (int i = 0; i < NR; i++)
          cfg_write(3'(i), RW'(32'h2000000 + ($urandom % 32'h800000) - 32'h400000));
      end
      dg = 16'($urandom);
      md = 1'($urandom);
      exp = model(dg, md);
      run_conv(dg, md, 0, 3'd0, '0, code, lat, bok);
      chk(code == exp, "R4 random", code, exp);
      if (t % 50 == 0) chk(lat == N && bok, "R6 random timing", lat, N);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule